// File: doc/BRIEF.md
# Interrupt Claim/Complete Gateway with Replay

This block keeps the per-source service state that sits between level-sensitive interrupt lines and the claim/complete handshake of a platform interrupt controller. Each source has three bits: pending, in-service (claimed) and a shadow bit. The shadow bit records that the line was asserted while the source was in service. An external arbiter chooses which ID to grant and presents it on the claim strobe. Software finishing a handler presents the same ID on the completion strobe. The block updates its state and echoes the granted ID back.

The key property is that an interrupt raised during service is never lost. If a source line is asserted at any time while that source is claimed, the pending bit is not touched. Instead, the shadow bit is set. When the completion arrives, the shadow bit is moved into pending, so the source is offered again. State is held in 32-bit words: source n lives in word n/32 at bit n%32. ID 0 is reserved to mean "no interrupt".

Top module: `plic_claim_gateway`

## Requirements
- R1: Source ID n is stored in word n/32 at bit n%32. Bit n of `pending_o` and of `claimed_o` reports source n, including IDs in the second word (for example 37).
- R2: One cycle after `claim_valid` with a nonzero ID n, `pending_o[n]` is 0, `claimed_o[n]` is 1 and `claim_id_o` equals n. `claim_id_o` holds its value in cycles without a claim.
- R3: While source n is not claimed, a high `src_level[n]` sets `pending_o[n]` one cycle later. The bit stays set after the line drops, until a claim of n.
- R4: While source n is claimed, a high `src_level[n]` never sets `pending_o[n]`.
- R5: A completion of an ID whose claimed bit is set clears `claimed_o` for that ID one cycle later.
- R6: If `src_level[n]` was high in any cycle while n was claimed, the completion of n sets `pending_o[n]` one cycle later, even if the line has since dropped.
- R7: The shadow bit is consumed by the completion that replays it. A later claim and completion of n with the line low leaves `pending_o[n]` at 0.
- R8: A completion of an ID that is not claimed changes neither `pending_o` nor `claimed_o`.
- R9: Reset (synchronous, active high) clears all pending, shadow and claimed bits, and sets `claim_id_o` to 0.
- R10: ID 0 is reserved. A claim of ID 0 returns 0 and changes no state. `src_level[0]` never sets any state.
- R11: When a claim and a completion of the same ID arrive in one cycle, the completion acts first. The ID ends up claimed and not pending. If the line is high in that cycle, the shadow bit is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Level-sensitive interrupt lines, bit n is source n |
| claim_valid | input | 1 | Claim strobe from the arbiter |
| claim_id | input | ID_W | ID being claimed |
| compl_valid | input | 1 | Completion strobe |
| compl_id | input | ID_W | ID being completed |
| pending_o | output | NUM_SRC | Pending bit per source |
| claimed_o | output | NUM_SRC | In-service bit per source |
| claim_id_o | output | ID_W | Registered ID returned for the last claim |

## Verification
The hardest situation to reach from the ports is a completion that lands in the same cycle as a fresh claim of the same ID while the source line is still high. In that cycle the replay, the re-claim and a new shadow capture all interact. The stimulus table first sets a line high, then claims it so the shadow bit fills, then issues claim and completion together. It then drops the line and completes once more, to show that exactly one replay survives and that a further claim/complete pair with the line low produces none.

// File: rtl/plic_gw_pkg.sv
package plic_gw_pkg;

    localparam int WORD_W   = 32;
    localparam int BIT_SEL  = 5;

    typedef logic [WORD_W-1:0] word_t;

    // Per-word service state: pending, shadow (arrived in service), claimed.
    typedef struct packed {
        word_t pend;
        word_t shad;
        word_t clm;
    } word_state_t;

    // Per-word strobe decode.
    typedef struct packed {
        word_t claim_m;
        word_t compl_m;
    } word_req_t;

    function automatic int unsigned words_for(input int unsigned n_src);
        return (n_src + WORD_W - 1) / WORD_W;
    endfunction

    // One-hot mask for an ID if it falls into the given word, else zero.
    function automatic word_t id_mask(input logic [31:0] id, input int unsigned widx);
        word_t m;
        m = '0;
        if (id[31:BIT_SEL] == 27'(widx))
            m = word_t'(1) << id[BIT_SEL-1:0];
        return m;
    endfunction

    // Bits of a word that belong to real, non-reserved sources.
    function automatic word_t valid_bits(input int unsigned widx, input int unsigned n_src);
        word_t m;
        m = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if ((widx * WORD_W + b) < n_src && (widx * WORD_W + b) != 0)
                m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/plic_gw_decode.sv
module plic_gw_decode
    import plic_gw_pkg::*;
#(
    parameter int unsigned WORD_IDX = 0,
    parameter int unsigned NUM_SRC  = 64,
    parameter int unsigned ID_W     = 6
) (
    input  logic            claim_valid,
    input  logic [ID_W-1:0] claim_id,
    input  logic            compl_valid,
    input  logic [ID_W-1:0] compl_id,
    output word_req_t       req
);
    localparam word_t VMASK = valid_bits(WORD_IDX, NUM_SRC);

    always_comb begin
        req.claim_m = claim_valid ? (id_mask(32'(claim_id), WORD_IDX) & VMASK) : '0;
        req.compl_m = compl_valid ? (id_mask(32'(compl_id), WORD_IDX) & VMASK) : '0;
    end
endmodule

// File: rtl/plic_gw_word.sv
module plic_gw_word
    import plic_gw_pkg::*;
#(
    parameter int unsigned WORD_IDX = 0,
    parameter int unsigned NUM_SRC  = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  word_t     lvl,
    input  word_req_t req,
    output word_t     pend_q,
    output word_t     clm_q
);
    localparam word_t VMASK = valid_bits(WORD_IDX, NUM_SRC);

    word_state_t st_q, st_d;
    word_t done_m, lvl_m;
    word_t c1, p1, h1, p2, c2;

    always_comb begin
        lvl_m  = lvl & VMASK;
        done_m = req.compl_m & st_q.clm;
        // completion first
        c1 = st_q.clm  & ~done_m;
        p1 = st_q.pend | (done_m & st_q.shad);
        h1 = st_q.shad & ~done_m;
        // then claim
        p2 = p1 & ~req.claim_m;
        c2 = c1 | req.claim_m;
        // then source levels against the resulting claimed state
        st_d.clm  = c2;
        st_d.shad = h1 | (lvl_m & c2);
        st_d.pend = p2 | (lvl_m & ~c2);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_q = st_q.pend;
    assign clm_q  = st_q.clm;

    AST_PEND_CLM_EXCL: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend & st_q.clm) == '0); // R4
    AST_SHAD_NEEDS_CLM: assert property (@(posedge clk) disable iff (rst)
        (st_q.shad & ~st_q.clm) == '0); // R6
    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst)
        (req.claim_m != '0) |=> (((st_q.clm & $past(req.claim_m)) == $past(req.claim_m))
                                 && ((st_q.pend & $past(req.claim_m)) == '0))); // R2
    AST_COMPL_FREES: assert property (@(posedge clk) disable iff (rst)
        ((req.compl_m & st_q.clm & ~req.claim_m) != '0)
        |=> ((st_q.clm & $past(req.compl_m)) == '0)); // R5
    AST_REPLAY: assert property (@(posedge clk) disable iff (rst)
        ((req.compl_m & st_q.shad & ~req.claim_m) != '0)
        |=> ((st_q.pend & $past(req.compl_m)) == $past(req.compl_m))); // R6
    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((st_q.pend | st_q.clm | st_q.shad) & ~VMASK) == '0); // R10
endmodule

// File: rtl/plic_gw_resp.sv
module plic_gw_resp #(
    parameter int unsigned ID_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            claim_valid,
    input  logic [ID_W-1:0] claim_id,
    output logic [ID_W-1:0] claim_id_o
);
    always_ff @(posedge clk) begin
        if (rst)              claim_id_o <= '0;
        else if (claim_valid) claim_id_o <= claim_id;
    end

    AST_RSP_ECHO: assert property (@(posedge clk) disable iff (rst)
        claim_valid |=> (claim_id_o == $past(claim_id))); // R2
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !claim_valid |=> $stable(claim_id_o)); // R2
    AST_RSP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (claim_valid && claim_id == '0) |=> (claim_id_o == '0)); // R10
endmodule

// File: rtl/plic_claim_gateway.sv
module plic_claim_gateway
    import plic_gw_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               claim_valid,
    input  logic [ID_W-1:0]    claim_id,
    input  logic               compl_valid,
    input  logic [ID_W-1:0]    compl_id,
    output logic [NUM_SRC-1:0] pending_o,
    output logic [NUM_SRC-1:0] claimed_o,
    output logic [ID_W-1:0]    claim_id_o
);
    localparam int unsigned NUM_WORDS = words_for(NUM_SRC);
    localparam int unsigned FLAT_W    = NUM_WORDS * WORD_W;

    logic [FLAT_W-1:0] lvl_flat, pend_flat, clm_flat;

    always_comb begin
        lvl_flat = '0;
        lvl_flat[NUM_SRC-1:0] = src_level;
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        word_req_t req;

        plic_gw_decode #(.WORD_IDX(w), .NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_dec (
            .claim_valid (claim_valid),
            .claim_id    (claim_id),
            .compl_valid (compl_valid),
            .compl_id    (compl_id),
            .req         (req)
        );

        plic_gw_word #(.WORD_IDX(w), .NUM_SRC(NUM_SRC)) u_word (
            .clk    (clk),
            .rst    (rst),
            .lvl    (lvl_flat[w*WORD_W +: WORD_W]),
            .req    (req),
            .pend_q (pend_flat[w*WORD_W +: WORD_W]),
            .clm_q  (clm_flat[w*WORD_W +: WORD_W])
        );
    end

    assign pending_o = pend_flat[NUM_SRC-1:0];
    assign claimed_o = clm_flat[NUM_SRC-1:0];

    plic_gw_resp #(.ID_W(ID_W)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .claim_valid (claim_valid),
        .claim_id    (claim_id),
        .claim_id_o  (claim_id_o)
    );
endmodule

// File: tb/plic_claim_gateway_bench.sv
`timescale 1ns/1ps
module plic_claim_gateway_bench;
    localparam int NS = 64;
    localparam int IW = 6;

    typedef struct packed {
        logic          set_lvl;
        logic [5:0]    lvl_id;
        logic          lvl_val;
        logic          clm_v;
        logic [5:0]    clm_id;
        logic          cmp_v;
        logic [5:0]    cmp_id;
        logic [5:0]    chk_id;
        logic          exp_pend;
        logic          exp_clm;
        logic [5:0]    exp_rsp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b1,6'd5,1'b1,  1'b0,6'd0,  1'b0,6'd0,  6'd5,  1'b1,1'b0,6'd0,  4'd3},  // R3 set
        '{1'b1,6'd5,1'b0,  1'b0,6'd0,  1'b0,6'd0,  6'd5,  1'b1,1'b0,6'd0,  4'd3},  // R3 sticky
        '{1'b0,6'd0,1'b0,  1'b1,6'd5,  1'b0,6'd0,  6'd5,  1'b0,1'b1,6'd5,  4'd2},  // R2 claim
        '{1'b1,6'd5,1'b1,  1'b0,6'd0,  1'b0,6'd0,  6'd5,  1'b0,1'b1,6'd5,  4'd4},  // R4 blocked
        '{1'b1,6'd5,1'b0,  1'b0,6'd0,  1'b0,6'd0,  6'd5,  1'b0,1'b1,6'd5,  4'd4},  // R4
        '{1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd5,  6'd5,  1'b1,1'b0,6'd5,  4'd6},  // R6 replay, R5
        '{1'b0,6'd0,1'b0,  1'b1,6'd5,  1'b0,6'd0,  6'd5,  1'b0,1'b1,6'd5,  4'd2},  // R2
        '{1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd5,  6'd5,  1'b0,1'b0,6'd5,  4'd7},  // R7 no repeat
        '{1'b1,6'd37,1'b1, 1'b0,6'd0,  1'b0,6'd0,  6'd37, 1'b1,1'b0,6'd5,  4'd1},  // R1 second word
        '{1'b1,6'd37,1'b0, 1'b1,6'd37, 1'b0,6'd0,  6'd37, 1'b0,1'b1,6'd37, 4'd1},  // R1 claim
        '{1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd36, 6'd37, 1'b0,1'b1,6'd37, 4'd8},  // R8 other ID
        '{1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd37, 6'd37, 1'b0,1'b0,6'd37, 4'd5},  // R5
        '{1'b0,6'd0,1'b0,  1'b1,6'd0,  1'b0,6'd0,  6'd37, 1'b0,1'b0,6'd0,  4'd10}, // R10 ID 0
        '{1'b1,6'd40,1'b1, 1'b0,6'd0,  1'b0,6'd0,  6'd40, 1'b1,1'b0,6'd0,  4'd3},  // R3
        '{1'b0,6'd0,1'b0,  1'b1,6'd40, 1'b0,6'd0,  6'd40, 1'b0,1'b1,6'd40, 4'd2},  // R2, shadow fills
        '{1'b0,6'd0,1'b0,  1'b1,6'd40, 1'b1,6'd40, 6'd40, 1'b0,1'b1,6'd40, 4'd11}, // R11 same cycle
        '{1'b1,6'd40,1'b0, 1'b0,6'd0,  1'b1,6'd40, 6'd40, 1'b1,1'b0,6'd40, 4'd6},  // R6 after R11
        '{1'b0,6'd0,1'b0,  1'b1,6'd40, 1'b0,6'd0,  6'd40, 1'b0,1'b1,6'd40, 4'd2},  // R2
        '{1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd40, 6'd40, 1'b0,1'b0,6'd40, 4'd7}   // R7
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_level = '0;
    logic          claim_valid = 1'b0;
    logic [IW-1:0] claim_id = '0;
    logic          compl_valid = 1'b0;
    logic [IW-1:0] compl_id = '0;
    logic [NS-1:0] pending_o, claimed_o;
    logic [IW-1:0] claim_id_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    plic_claim_gateway #(.NUM_SRC(NS)) u_plic_claim_gateway (
        .clk(clk), .rst(rst), .src_level(src_level),
        .claim_valid(claim_valid), .claim_id(claim_id),
        .compl_valid(compl_valid), .compl_id(compl_id),
        .pending_o(pending_o), .claimed_o(claimed_o), .claim_id_o(claim_id_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NS-1:0] snap_p, snap_c;
        @(negedge clk);
        tick();
        // R9 reset state
        check("R9", "pending at reset", 64'(pending_o), 64'd0);
        check("R9", "claimed at reset", 64'(claimed_o), 64'd0);
        check("R9", "claim id at reset", 64'(claim_id_o), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].set_lvl) src_level[TBL[i].lvl_id] = TBL[i].lvl_val;
            claim_valid = TBL[i].clm_v;
            claim_id    = TBL[i].clm_id;
            compl_valid = TBL[i].cmp_v;
            compl_id    = TBL[i].cmp_id;
            tick();
            check($sformatf("R%0d", TBL[i].req), $sformatf("step %0d pending", i),
                  64'(pending_o[TBL[i].chk_id]), 64'(TBL[i].exp_pend));
            check($sformatf("R%0d", TBL[i].req), $sformatf("step %0d claimed", i),
                  64'(claimed_o[TBL[i].chk_id]), 64'(TBL[i].exp_clm));
            check($sformatf("R%0d", TBL[i].req), $sformatf("step %0d claim id", i),
                  64'(claim_id_o), 64'(TBL[i].exp_rsp));
        end
        claim_valid = 1'b0;
        compl_valid = 1'b0;
        src_level   = '0;
        tick();

        // R10: source line 0 is reserved
        src_level[0] = 1'b1;
        tick();
        tick();
        check("R10", "line 0 pending vector", 64'(pending_o), 64'd0);
        check("R10", "line 0 claimed vector", 64'(claimed_o), 64'd0);
        src_level[0] = 1'b0;

        // R8: completions of unclaimed IDs leave state alone
        src_level[9] = 1'b1;
        claim_valid = 1'b1; claim_id = 6'd20;
        tick();
        claim_valid = 1'b0;
        check("R8", "setup pending 9", 64'(pending_o[9]), 64'd1);
        check("R8", "setup claimed 20", 64'(claimed_o[20]), 64'd1);
        snap_p = pending_o; snap_c = claimed_o;
        compl_valid = 1'b1; compl_id = 6'd9;
        tick();
        compl_id = 6'd21;
        tick();
        compl_valid = 1'b0;
        check("R8", "pending vector unchanged", 64'(pending_o), 64'(snap_p));
        check("R8", "claimed vector unchanged", 64'(claimed_o), 64'(snap_c));

        // R9: reset in mid-operation
        src_level = '0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R9", "pending after reset", 64'(pending_o), 64'd0);
        check("R9", "claimed after reset", 64'(claimed_o), 64'd0);
        check("R9", "claim id after reset", 64'(claim_id_o), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule